// File: doc/BRIEF.md
# Variable Word Size Memory Access Unit

This unit fronts one tile memory that software addresses in logical words rather than bytes. The word size is set per tile through a small size code. For each request the unit turns the logical word index into a physical line and a byte offset within that line. A physical line is 48 bytes, spread over three 16-byte SRAM banks that are accessed together. Because every supported size fits a whole number of words into a line, and that count always has the form 2^k or 3·2^k, the mapping needs only shifts and one divide-by-3 stage. No general divider is used.

A read gathers the whole line from the three banks and cuts out the addressed word. It packs the word into consecutive 16-bit destination registers, with the first byte in the low half of the first register. It then broadcasts the result, the destination register number and the register count exactly two cycles after the request. A write uses the same mapping and changes only the bytes of the addressed word. At most one request arrives per cycle. The request side is a plain valid strobe with no ready: the unit accepts every request in the cycle it is presented and never applies back-pressure. The response side is a one-cycle valid pulse that every consumer must take in that cycle, because the latency is fixed.

Top module: `vw_mem_access`

## Requirements
- R1: `cfg_size_code` selects the word size: codes 0..11 mean 1, 2, 3, 4, 6, 7, 8, 10, 11, 12, 14 and 16 bytes. The words-per-line count is floor(48/size). The line is index / count, and the byte offset in the line is (index mod count) × size. Line byte b sits in bank b/16, at byte b mod 16.
- R2: A word never crosses a line. The first index of each line starts at byte 0 of the next line, and any spare bytes at the end of a line are never read or written.
- R3: A read accepted in cycle c raises `rsp_valid` for exactly one cycle, in cycle c+2, for every size. A write never produces a response.
- R4: Word byte j is placed in bits [8j+7:8j] of `rsp_regs`, so byte 0 lands in the low byte of register 0. `rsp_nregs` equals ceil(size/2). The unused upper byte for an odd size, and all registers beyond `rsp_nregs`, read as zero.
- R5: A write stores `req_wdata` bytes 0..size-1 into the addressed word and leaves every other byte of the memory unchanged.
- R6: The reserved codes 12..15 behave exactly like code 11 (16 bytes).
- R7: `rsp_dst` returns the `req_dst` of the read that the response belongs to.
- R8: A read issued in the cycle before a write to the same word returns the old contents. A read issued in the cycle after that write returns the new contents.
- R9: While reset is held and in the first cycle after it, `rsp_valid` is low.
- R10: The size code is sampled with each request. Back-to-back reads with different codes are each mapped and extracted with their own size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_code | input | 4 | Word size code for the tile (R1, R6) |
| req_valid | input | 1 | Request strobe; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 16 | Logical word index |
| req_dst | input | 5 | First destination register of a read |
| req_wdata | input | 128 | Write data, word byte j in bits [8j+7:8j] |
| rsp_valid | output | 1 | One-cycle read result broadcast |
| rsp_dst | output | 5 | First destination register |
| rsp_nregs | output | 4 | Number of 16-bit registers filled (1..8) |
| rsp_regs | output | 128 | Packed registers, register i in bits [16i+15:16i] |

## Verification
Two things can meet in one cycle: a write being stored in the banks, and a read that touches the same word. The read may already be in flight, or it may be issued right after the write. The bench issues a read, then a write to the same word in the next cycle, then a read again in the cycle after that. It then checks that the first response carries the bytes from before the write and the second carries the bytes written. It also overlaps two reads with different size codes, so that one read's extraction happens in the same cycle as the next read's address mapping. Each response is judged against its own size and offset.

// File: rtl/vw_pkg.sv
package vw_pkg;
  localparam int BANKS      = 3;
  localparam int BANK_BYTES = 16;
  localparam int LINE_BYTES = BANKS * BANK_BYTES;
  localparam int MAXW       = 16;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  // Word format: size in bytes, and words per line = (three ? 3 : 1) << shift
  typedef struct packed {
    logic [4:0] size;
    logic [2:0] shift;
    logic       three;
  } wfmt_t;

  function automatic wfmt_t decode_fmt(input logic [3:0] code);
    wfmt_t f;
    unique case (code)
      4'd0:    f = '{size: 5'd1,  shift: 3'd4, three: 1'b1}; // 48
      4'd1:    f = '{size: 5'd2,  shift: 3'd3, three: 1'b1}; // 24
      4'd2:    f = '{size: 5'd3,  shift: 3'd4, three: 1'b0}; // 16
      4'd3:    f = '{size: 5'd4,  shift: 3'd2, three: 1'b1}; // 12
      4'd4:    f = '{size: 5'd6,  shift: 3'd3, three: 1'b0}; // 8
      4'd5:    f = '{size: 5'd7,  shift: 3'd1, three: 1'b1}; // 6
      4'd6:    f = '{size: 5'd8,  shift: 3'd1, three: 1'b1}; // 6
      4'd7:    f = '{size: 5'd10, shift: 3'd2, three: 1'b0}; // 4
      4'd8:    f = '{size: 5'd11, shift: 3'd2, three: 1'b0}; // 4
      4'd9:    f = '{size: 5'd12, shift: 3'd2, three: 1'b0}; // 4
      4'd10:   f = '{size: 5'd14, shift: 3'd0, three: 1'b1}; // 3
      default: f = '{size: 5'd16, shift: 3'd0, three: 1'b1}; // 3, codes 11..15
    endcase
    return f;
  endfunction
endpackage

// File: rtl/vw_div3.sv
module vw_div3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] num,
  output logic [W-1:0] quo,
  output logic [1:0]   rem
);
  // Restoring division by a constant three, one quotient bit per step
  always_comb begin
    logic [2:0] part;
    logic [1:0] r;
    r   = 2'd0;
    quo = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {r, num[i]};
      if (part >= 3'd3) begin
        quo[i] = 1'b1;
        part   = part - 3'd3;
      end
      r = part[1:0];
    end
    rem = r;
  end
endmodule

// File: rtl/vw_addr_map.sv
module vw_addr_map
  import vw_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int LINE_AW = 10
) (
  input  logic [IDX_W-1:0]   index,
  input  wfmt_t              fmt,
  output logic [LINE_AW-1:0] line,
  output logic [OFF_W-1:0]   off
);
  localparam int SLOT_W = OFF_W;

  logic [IDX_W-1:0] hi;
  logic [IDX_W-1:0] lo_mask;
  logic [IDX_W-1:0] q3;
  logic [1:0]       r3;
  logic [IDX_W-1:0] line_full;
  logic [IDX_W-1:0] slot_full;
  logic [SLOT_W+4:0] prod;

  assign hi      = index >> fmt.shift;
  assign lo_mask = ~({IDX_W{1'b1}} << fmt.shift);

  vw_div3 #(.W(IDX_W)) u_div3 (.num(hi), .quo(q3), .rem(r3));

  always_comb begin
    if (fmt.three) begin
      line_full = q3;
      slot_full = ({{(IDX_W-2){1'b0}}, r3} << fmt.shift) | (index & lo_mask);
    end else begin
      line_full = hi;
      slot_full = index & lo_mask;
    end
    prod = slot_full[SLOT_W-1:0] * fmt.size;
  end

  assign line = line_full[LINE_AW-1:0];
  assign off  = prod[OFF_W-1:0];
endmodule

// File: rtl/vw_bank.sv
module vw_bank #(
  parameter int BYTES = 16,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [BYTES-1:0] be,
  input  logic [8*BYTES-1:0] wdata,
  output logic [8*BYTES-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [8*BYTES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/vw_mem_access.sv
module vw_mem_access
  import vw_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int LINE_AW = 10,
  parameter int REG_AW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         cfg_size_code,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [REG_AW-1:0]  req_dst,
  input  logic [8*MAXW-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [REG_AW-1:0]  rsp_dst,
  output logic [3:0]         rsp_nregs,
  output logic [8*MAXW-1:0]  rsp_regs
);
  localparam int LINE_BITS = 8 * LINE_BYTES;
  localparam int BANK_BITS = 8 * BANK_BYTES;
  localparam int WBITS     = 8 * MAXW;

  // ---------------- stage 0: map and bank access ----------------
  wfmt_t              fmt;
  logic [LINE_AW-1:0] map_line;
  logic [OFF_W-1:0]   map_off;
  logic [MAXW-1:0]    word_be;
  logic [LINE_BYTES-1:0] line_be;
  logic [LINE_BITS-1:0]  line_wd;
  logic [LINE_BITS-1:0]  line_rd;
  logic               do_rd, do_wr;

  assign fmt = decode_fmt(cfg_size_code);

  vw_addr_map #(.IDX_W(IDX_W), .LINE_AW(LINE_AW)) u_map (
    .index(req_index), .fmt(fmt), .line(map_line), .off(map_off)
  );

  always_comb begin
    for (int j = 0; j < MAXW; j++) word_be[j] = (5'(j) < fmt.size);
  end

  assign line_be = {{(LINE_BYTES-MAXW){1'b0}}, word_be} << map_off;
  assign line_wd = {{(LINE_BITS-WBITS){1'b0}}, req_wdata} << {map_off, 3'b000};
  assign do_rd   = req_valid && !req_write;
  assign do_wr   = req_valid && req_write;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [BANK_BYTES-1:0] bbe;
    assign bbe = line_be[g*BANK_BYTES +: BANK_BYTES];
    vw_bank #(.BYTES(BANK_BYTES), .AW(LINE_AW)) u_bank (
      .clk   (clk),
      .rd_en (do_rd),
      .wr_en (do_wr && (|bbe)),
      .addr  (map_line),
      .be    (bbe),
      .wdata (line_wd[g*BANK_BITS +: BANK_BITS]),
      .rdata (line_rd[g*BANK_BITS +: BANK_BITS])
    );
  end

  // ---------------- stage 1: extract and pack ----------------
  logic              s1_valid;
  logic [OFF_W-1:0]  s1_off;
  logic [4:0]        s1_size;
  logic [REG_AW-1:0] s1_dst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_off   <= '0;
      s1_size  <= '0;
      s1_dst   <= '0;
    end else begin
      s1_valid <= do_rd;
      if (do_rd) begin
        s1_off  <= map_off;
        s1_size <= fmt.size;
        s1_dst  <= req_dst;
      end
    end
  end

  logic [LINE_BITS-1:0] shifted;
  logic [WBITS-1:0]     packed_w;
  logic [5:0]           size_up;

  assign shifted = line_rd >> {s1_off, 3'b000};
  assign size_up = {1'b0, s1_size} + 6'd1;

  always_comb begin
    for (int j = 0; j < MAXW; j++)
      packed_w[8*j +: 8] = (5'(j) < s1_size) ? shifted[8*j +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_dst   <= '0;
      rsp_nregs <= '0;
      rsp_regs  <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_dst   <= s1_dst;
        rsp_nregs <= size_up[4:1];
        rsp_regs  <= packed_w;
      end
    end
  end
endmodule

// File: rtl/vw_mem_access_chk.sv
module vw_mem_access_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_write,
  input logic [4:0]   req_dst,
  input logic         rsp_valid,
  input logic [4:0]   rsp_dst,
  input logic [3:0]   rsp_nregs,
  input logic [127:0] rsp_regs,
  input logic [5:0]   map_off,
  input logic [4:0]   map_size
);
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> ##2 rsp_valid);

  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write, 2));

  a_r7_dst_echo: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_dst == $past(req_dst, 2)));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_regs >> {rsp_nregs, 4'b0000}) == 128'd0));

  a_r4_nregs_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_nregs >= 4'd1 && rsp_nregs <= 4'd8));

  a_r2_word_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, map_off} + {2'b00, map_size} <= 7'd48));
endmodule

bind vw_mem_access vw_mem_access_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_dst   (req_dst),
  .rsp_valid (rsp_valid),
  .rsp_dst   (rsp_dst),
  .rsp_nregs (rsp_nregs),
  .rsp_regs  (rsp_regs),
  .map_off   (map_off),
  .map_size  (fmt.size)
);

// File: tb/vw_mem_access_test.sv
module vw_mem_access_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   cfg_size_code;
  logic         req_valid, req_write;
  logic [15:0]  req_index;
  logic [4:0]   req_dst;
  logic [127:0] req_wdata;
  logic         rsp_valid;
  logic [4:0]   rsp_dst;
  logic [3:0]   rsp_nregs;
  logic [127:0] rsp_regs;

  always #4 clk = ~clk; // 125 MHz

  vw_mem_access uut (
    .clk(clk), .rst_n(rst_n), .cfg_size_code(cfg_size_code),
    .req_valid(req_valid), .req_write(req_write), .req_index(req_index),
    .req_dst(req_dst), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_dst(rsp_dst), .rsp_nregs(rsp_nregs), .rsp_regs(rsp_regs)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mdl [0:767]; // bench model of lines 0..15

  // {code, index, expected line, expected offset}, worked by hand from R1/R6
  localparam logic [35:0] VEC [15] = '{
    {4'd0,  16'd47, 8'd0,  8'd47},
    {4'd0,  16'd48, 8'd1,  8'd0 },
    {4'd1,  16'd25, 8'd1,  8'd2 },
    {4'd2,  16'd33, 8'd2,  8'd3 },
    {4'd3,  16'd11, 8'd0,  8'd44},
    {4'd4,  16'd17, 8'd2,  8'd6 },
    {4'd5,  16'd13, 8'd2,  8'd7 },
    {4'd6,  16'd5,  8'd0,  8'd40},
    {4'd7,  16'd7,  8'd1,  8'd30},
    {4'd8,  16'd9,  8'd2,  8'd11},
    {4'd9,  16'd15, 8'd3,  8'd36},
    {4'd10, 16'd44, 8'd14, 8'd28},
    {4'd11, 16'd29, 8'd9,  8'd32},
    {4'd12, 16'd2,  8'd0,  8'd32},
    {4'd15, 16'd4,  8'd1,  8'd16}
  };

  function automatic int size_of(input logic [3:0] c);
    case (c)
      4'd0: return 1;   4'd1: return 2;   4'd2: return 3;   4'd3: return 4;
      4'd4: return 6;   4'd5: return 7;   4'd6: return 8;   4'd7: return 10;
      4'd8: return 11;  4'd9: return 12;  4'd10: return 14;
      default: return 16;
    endcase
  endfunction

  function automatic logic [127:0] expect_word(input int line, input int off, input int sz);
    logic [127:0] w = '0;
    for (int j = 0; j < sz; j++) w[8*j +: 8] = mdl[line*48 + off + j];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic drive(input bit wr, input logic [3:0] c, input int idx, input logic [4:0] d, input logic [127:0] wd);
    req_valid = 1'b1; req_write = wr; cfg_size_code = c;
    req_index = 16'(idx); req_dst = d; req_wdata = wd;
  endtask

  // model write using independent mapping (division by words-per-line)
  task automatic model_write(input logic [3:0] c, input int idx, input logic [127:0] wd);
    int sz = size_of(c);
    int wpl = 48 / sz;
    int base = (idx / wpl) * 48 + (idx % wpl) * sz;
    for (int j = 0; j < sz; j++) mdl[base + j] = wd[8*j +: 8];
  endtask

  task automatic read_check(input logic [3:0] c, input int line, input int off, input int idx,
                            input logic [4:0] d, input string req);
    int sz = size_of(c);
    logic [127:0] exp = expect_word(line, off, sz);
    @(negedge clk); drive(1'b0, c, idx, d, '0);
    @(negedge clk); idle();
    check(rsp_valid == 1'b0, "R3 early", {127'd0, rsp_valid}, 128'd0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R3 valid", {127'd0, rsp_valid}, 128'd1);
    check(rsp_regs == exp, req, rsp_regs, exp);
    check(rsp_nregs == 4'((sz + 1) / 2), "R4 nregs", {124'd0, rsp_nregs}, 128'((sz + 1) / 2));
    check(rsp_dst == d, "R7 dst", {123'd0, rsp_dst}, {123'd0, d});
    @(negedge clk);
    check(rsp_valid == 1'b0, "R3 single pulse", {127'd0, rsp_valid}, 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] wd, old_w, new_w;
    rst_n = 1'b0; idle(); cfg_size_code = '0; req_index = '0; req_dst = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9 reset", {127'd0, rsp_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 after reset", {127'd0, rsp_valid}, 128'd0);

    // fill lines 0..15 with 16-byte writes (code 11: index i covers bytes 16i..16i+15)
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 16; j++) wd[8*j +: 8] = 8'((i*16 + j) * 37 + 11);
      drive(1'b1, 4'd11, i, 5'd0, wd);
      model_write(4'd11, i, wd);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R3 write has no response", {127'd0, rsp_valid}, 128'd0);
    end
    idle();
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b0, "R3 write has no response", {127'd0, rsp_valid}, 128'd0);

    // vector table: R1 mapping, R2 line boundary, R4 packing, R6 reserved codes
    foreach (VEC[v]) begin
      read_check(VEC[v][35:32], int'(VEC[v][15:8]), int'(VEC[v][7:0]),
                 int'(VEC[v][31:16]), 5'(v + 3), (v >= 13) ? "R6 reserved code" : "R1 R2 R4 read");
    end

    // R5: 10-byte write to index 5 (line 1, byte 10); neighbours 4 and 6 unchanged
    for (int j = 0; j < 16; j++) wd[8*j +: 8] = 8'hA0 + 8'(j);
    @(negedge clk); drive(1'b1, 4'd7, 5, 5'd0, wd);
    model_write(4'd7, 5, wd);
    @(negedge clk); idle();
    check(rsp_valid == 1'b0, "R3 write has no response", {127'd0, rsp_valid}, 128'd0);
    read_check(4'd7, 1, 10, 5, 5'd9, "R5 written word");
    read_check(4'd7, 1, 0, 4, 5'd10, "R5 left neighbour");
    read_check(4'd7, 1, 20, 6, 5'd11, "R5 right neighbour");
    read_check(4'd11, 1, 0, 3, 5'd12, "R5 whole bank unchanged outside word");

    // R8: read, write same word next cycle, read again the cycle after
    old_w = expect_word(1, 10, 10);
    for (int j = 0; j < 16; j++) wd[8*j +: 8] = 8'hC0 + 8'(j);
    new_w = {48'd0, wd[79:0]};
    @(negedge clk); drive(1'b0, 4'd7, 5, 5'd20, '0);
    @(negedge clk); drive(1'b1, 4'd7, 5, 5'd0, wd);
    @(negedge clk);
    check(rsp_valid && rsp_regs == old_w, "R8 read before write", rsp_regs, old_w);
    drive(1'b0, 4'd7, 5, 5'd21, '0);
    @(negedge clk); idle();
    check(rsp_valid == 1'b0, "R3 no response for write", {127'd0, rsp_valid}, 128'd0);
    @(negedge clk);
    check(rsp_valid && rsp_regs == new_w, "R8 read after write", rsp_regs, new_w);
    check(rsp_dst == 5'd21, "R7 dst after write", {123'd0, rsp_dst}, 128'd21);
    model_write(4'd7, 5, wd);

    // R10: back-to-back reads with different size codes
    @(negedge clk); drive(1'b0, 4'd2, 33, 5'd1, '0);
    @(negedge clk); drive(1'b0, 4'd9, 15, 5'd2, '0);
    @(negedge clk); idle();
    check(rsp_valid && rsp_regs == expect_word(2, 3, 3) && rsp_nregs == 4'd2,
          "R10 first of pair", rsp_regs, expect_word(2, 3, 3));
    @(negedge clk);
    check(rsp_valid && rsp_regs == expect_word(3, 36, 12) && rsp_nregs == 4'd6,
          "R10 second of pair", rsp_regs, expect_word(3, 36, 12));
    check(rsp_dst == 5'd2, "R7 dst of pair", {123'd0, rsp_dst}, 128'd2);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R3 pulse ends", {127'd0, rsp_valid}, 128'd0);

    // R4 odd size 11 at line 2 byte 11: upper byte of register 5 is zero
    read_check(4'd8, 2, 11, 9, 5'd30, "R4 odd size upper byte zero");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule